// File: doc/BRIEF.md
# Framed Serial Transmit Sequencer

This block runs the transmit side of a synchronous, bit-oriented serial link. It shares a 256-byte buffer with a processor. The payload sits at the low offsets. The two top offsets serve as control and status words: the top offset (0xFF) takes the transmit length and later reports completion, and the one below it (0xFE) reports whether the bit clock is present. The processor-side decode is outside the block. It gives the block a one-cycle strobe whenever the processor writes either of those two offsets.

When the length location is written, the block reads the length back through a request/acknowledge memory port. If the length is valid, the block fetches the payload bytes one at a time and hands each framing item to an external bit serializer. It computes a CRC-16 over the payload and appends it. When the frame is done, it overwrites the length location with 0xFF and pulses an interrupt. The block also watches a clock-okay input and mirrors it into the status location. A change in that input raises an interrupt. A processor write to the status location only restores the mirrored value.

Top module: `hdlc_tx_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `ser_en`, `mem_req` and `irq` are all 0.
- R2: A length strobe with a value of 1 to 253 stored at offset 0xFF starts a frame. The frame is sent as items in this order:
  - an opening flag item (`ser_flag`=1, `ser_data`=0x7E);
  - the payload bytes from offsets 0 up to length-1, in ascending order, each with `ser_flag`=0;
  - the CRC low byte, then the CRC high byte;
  - a closing flag item.
- R3: The CRC is the bit-reflected CCITT CRC-16 (reversed polynomial 0x8408, data taken least significant bit first). It starts from the parameter `CRC_INIT` (default 0xFFFF) at the start of every frame, covers the payload only and has no final inversion.
- R4: A length strobe that finds 0x00, 0xFE or 0xFF at offset 0xFF is ignored. No item is sent, no interrupt is raised and offset 0xFF keeps its value.
- R5: After the closing flag, the block writes 0xFF to offset 0xFF. `irq` pulses in the cycle after the acknowledge of that write.
- R6: When the synchronised `clk_ok` input differs from the last mirrored state, the block writes 0xFF (clock present) or 0x00 (clock absent) to offset 0xFE and pulses `irq` once.
- R7: A strobe on `clk_wr`, which marks a processor write to offset 0xFE, makes the block rewrite the current mirrored status there. No interrupt is raised.
- R8: A length strobe while `clk_ok` is low is dropped. No item is sent, no interrupt is raised and offset 0xFF is left unchanged.
- R9: A length strobe that arrives while a frame is in progress is ignored. Only the running frame is sent, and only one completion interrupt is raised.
- R10: A memory access holds `mem_req`, `mem_addr`, `mem_rwn` (1 means read) and `mem_wdata` stable until `mem_ack`. Read data is taken in the acknowledge cycle.
- R11: Each item is a single-cycle `ser_en` pulse. It is issued only after a `ser_next` pulse has been seen since the previous item. A `ser_next` pulse that arrives early is remembered.
- R12: `irq` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ok | input | 1 | Bit clock present indication |
| len_wr | input | 1 | One-cycle strobe: processor wrote the length location |
| clk_wr | input | 1 | One-cycle strobe: processor wrote the clock status location |
| mem_req | output | 1 | Buffer access request |
| mem_rwn | output | 1 | 1 for read, 0 for write |
| mem_addr | output | ADDR_W | Buffer offset |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle access acknowledge |
| ser_en | output | 1 | One-cycle item strobe to the serializer |
| ser_flag | output | 1 | Item is a flag rather than a data byte |
| ser_data | output | 8 | Item byte |
| ser_next | input | 1 | Serializer ready for the next item |
| irq | output | 1 | Transmit interrupt pulse |

## Verification
The assertions rely on three assumptions about the neighbours:
- The buffer raises `mem_ack` for a single cycle and only while `mem_req` is high.
- The serializer never pulses `ser_next` in the same cycle that it receives an item.
- The strobes `len_wr` and `clk_wr` are single-cycle pulses.

The bench's buffer model keeps to these rules. It acknowledges two cycles after seeing a request, performs writes in the acknowledge cycle, and drops the acknowledge on the next cycle. The serializer model raises `ser_next` once after reset and then six cycles after each item. The processor side is modelled by a task that updates the buffer and then pulses one strobe.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK_WR,
    ST_LEN_RD,
    ST_FLAG_OPEN,
    ST_BYTE_RD,
    ST_BYTE_TX,
    ST_CRC_LO,
    ST_CRC_HI,
    ST_FLAG_CLOSE,
    ST_DONE_WR
  } tx_state_e;

  localparam int EVT_START = 0;
  localparam int EVT_QUIET = 1;
  localparam int EVT_NEXT  = 2;
  localparam int EVT_N     = 3;

  // one byte of reflected CRC update, least significant data bit first
  function automatic logic [15:0] crc_step(input logic [15:0] cur,
                                           input logic [7:0]  din,
                                           input logic [15:0] poly_rev);
    logic [15:0] c;
    c = cur ^ {8'h00, din};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ poly_rev) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_tx_crc16.sv
module hdlc_tx_crc16 #(
  parameter logic [15:0] INIT     = 16'hFFFF,
  parameter logic [15:0] POLY_REV = 16'h8408
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import hdlc_tx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= INIT;
    end else if (en) begin
      crc <= crc_step(crc, din, POLY_REV);
    end
  end

endmodule

// File: rtl/hdlc_tx_sticky.sv
module hdlc_tx_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar g = 0; g < N; g++) begin : g_evt
    logic held;
    always_ff @(posedge clk) begin
      if (rst) begin
        held <= 1'b0;
      end else if (set[g]) begin
        held <= 1'b1;
      end else if (clr[g]) begin
        held <= 1'b0;
      end
    end
    assign flag[g] = held;
  end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  FLAG_BYTE = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_ok_s,
  input  logic              start_pend,
  input  logic              quiet_pend,
  input  logic              next_pend,
  output logic              start_clr,
  output logic              quiet_clr,
  output logic              next_clr,
  output logic              frame_idle,
  output logic              crc_clr,
  output logic              crc_en,
  output logic [7:0]        crc_din,
  input  logic [15:0]       crc,
  output logic              mem_req,
  output logic              mem_rwn,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              ser_en,
  output logic              ser_flag,
  output logic [7:0]        ser_data,
  output logic              irq
);
  import hdlc_tx_pkg::*;

  localparam logic [ADDR_W-1:0] LEN_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] CLK_ADDR = LEN_ADDR - 1'b1;
  localparam int                MAX_LEN  = (1 << ADDR_W) - 3;

  tx_state_e         state;
  logic [ADDR_W-1:0] len;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] idx_nx;
  logic [7:0]        byte_q;
  logic              clk_stat;
  logic              quiet_wr;
  logic              chg;
  logic              len_ok;
  logic              wait_ser;

  assign idx_nx   = idx + 1'b1;
  assign chg      = (clk_ok_s != clk_stat);
  assign len_ok   = (mem_rdata != 8'h00) && (int'(mem_rdata) <= MAX_LEN);
  assign wait_ser = (state == ST_FLAG_OPEN) || (state == ST_BYTE_TX) ||
                    (state == ST_CRC_LO) || (state == ST_CRC_HI) ||
                    (state == ST_FLAG_CLOSE);

  assign frame_idle = (state == ST_IDLE) || (state == ST_CLK_WR);
  assign start_clr  = (state == ST_IDLE) && !chg && !quiet_pend;
  assign quiet_clr  = (state == ST_IDLE);
  assign next_clr   = wait_ser && next_pend;
  assign crc_clr    = (state == ST_LEN_RD) && mem_ack;
  assign crc_en     = (state == ST_BYTE_TX) && next_pend;
  assign crc_din    = byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_rwn   <= 1'b1;
      mem_addr  <= '0;
      mem_wdata <= 8'h00;
      ser_en    <= 1'b0;
      ser_flag  <= 1'b0;
      ser_data  <= 8'h00;
      irq       <= 1'b0;
      len       <= '0;
      idx       <= '0;
      byte_q    <= 8'h00;
      clk_stat  <= 1'b0;
      quiet_wr  <= 1'b0;
    end else begin
      ser_en <= 1'b0;
      irq    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (chg) begin
            mem_req   <= 1'b1;
            mem_rwn   <= 1'b0;
            mem_addr  <= CLK_ADDR;
            mem_wdata <= {8{clk_ok_s}};
            clk_stat  <= clk_ok_s;
            quiet_wr  <= 1'b0;
            state     <= ST_CLK_WR;
          end else if (quiet_pend) begin
            mem_req   <= 1'b1;
            mem_rwn   <= 1'b0;
            mem_addr  <= CLK_ADDR;
            mem_wdata <= {8{clk_stat}};
            quiet_wr  <= 1'b1;
            state     <= ST_CLK_WR;
          end else if (start_pend && clk_ok_s) begin
            mem_req  <= 1'b1;
            mem_rwn  <= 1'b1;
            mem_addr <= LEN_ADDR;
            state    <= ST_LEN_RD;
          end
        end
        ST_CLK_WR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            irq     <= !quiet_wr;
            state   <= ST_IDLE;
          end
        end
        ST_LEN_RD: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            len     <= ADDR_W'(mem_rdata);
            idx     <= '0;
            state   <= len_ok ? ST_FLAG_OPEN : ST_IDLE;
          end
        end
        ST_FLAG_OPEN: begin
          if (next_pend) begin
            ser_en   <= 1'b1;
            ser_flag <= 1'b1;
            ser_data <= FLAG_BYTE;
            mem_req  <= 1'b1;
            mem_rwn  <= 1'b1;
            mem_addr <= idx;
            state    <= ST_BYTE_RD;
          end
        end
        ST_BYTE_RD: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            byte_q  <= mem_rdata;
            state   <= ST_BYTE_TX;
          end
        end
        ST_BYTE_TX: begin
          if (next_pend) begin
            ser_en   <= 1'b1;
            ser_flag <= 1'b0;
            ser_data <= byte_q;
            idx      <= idx_nx;
            if (idx_nx == len) begin
              state <= ST_CRC_LO;
            end else begin
              mem_req  <= 1'b1;
              mem_rwn  <= 1'b1;
              mem_addr <= idx_nx;
              state    <= ST_BYTE_RD;
            end
          end
        end
        ST_CRC_LO: begin
          if (next_pend) begin
            ser_en   <= 1'b1;
            ser_flag <= 1'b0;
            ser_data <= crc[7:0];
            state    <= ST_CRC_HI;
          end
        end
        ST_CRC_HI: begin
          if (next_pend) begin
            ser_en   <= 1'b1;
            ser_flag <= 1'b0;
            ser_data <= crc[15:8];
            state    <= ST_FLAG_CLOSE;
          end
        end
        ST_FLAG_CLOSE: begin
          if (next_pend) begin
            ser_en    <= 1'b1;
            ser_flag  <= 1'b1;
            ser_data  <= FLAG_BYTE;
            mem_req   <= 1'b1;
            mem_rwn   <= 1'b0;
            mem_addr  <= LEN_ADDR;
            mem_wdata <= 8'hFF;
            state     <= ST_DONE_WR;
          end
        end
        ST_DONE_WR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            irq     <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_rwn) && $stable(mem_wdata))); // R10

  AST_IRQ_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_req && mem_ack && !mem_rwn)); // R5

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R12

  AST_EN_AFTER_NEXT: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> $past(next_pend)); // R11

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ser_en |=> !ser_en); // R11

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq #(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [7:0]  FLAG_BYTE = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_ok,
  input  logic              len_wr,
  input  logic              clk_wr,
  output logic              mem_req,
  output logic              mem_rwn,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              ser_en,
  output logic              ser_flag,
  output logic [7:0]        ser_data,
  input  logic              ser_next,
  output logic              irq
);
  import hdlc_tx_pkg::*;

  logic             clk_ok_q;
  logic [EVT_N-1:0] evt_set;
  logic [EVT_N-1:0] evt_clr;
  logic [EVT_N-1:0] evt_pend;
  logic             frame_idle;
  logic             crc_clr;
  logic             crc_en;
  logic [7:0]       crc_din;
  logic [15:0]      crc;

  always_ff @(posedge clk) begin
    if (rst) clk_ok_q <= 1'b0;
    else     clk_ok_q <= clk_ok;
  end

  assign evt_set[EVT_START] = len_wr && frame_idle;
  assign evt_set[EVT_QUIET] = clk_wr;
  assign evt_set[EVT_NEXT]  = ser_next;

  hdlc_tx_sticky #(.N(EVT_N)) u_evt (
    .clk  (clk),
    .rst  (rst),
    .set  (evt_set),
    .clr  (evt_clr),
    .flag (evt_pend)
  );

  hdlc_tx_crc16 #(.INIT(CRC_INIT), .POLY_REV(CRC_POLY)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (crc_clr),
    .en  (crc_en),
    .din (crc_din),
    .crc (crc)
  );

  hdlc_tx_ctrl #(.ADDR_W(ADDR_W), .FLAG_BYTE(FLAG_BYTE)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clk_ok_s   (clk_ok_q),
    .start_pend (evt_pend[EVT_START]),
    .quiet_pend (evt_pend[EVT_QUIET]),
    .next_pend  (evt_pend[EVT_NEXT]),
    .start_clr  (evt_clr[EVT_START]),
    .quiet_clr  (evt_clr[EVT_QUIET]),
    .next_clr   (evt_clr[EVT_NEXT]),
    .frame_idle (frame_idle),
    .crc_clr    (crc_clr),
    .crc_en     (crc_en),
    .crc_din    (crc_din),
    .crc        (crc),
    .mem_req    (mem_req),
    .mem_rwn    (mem_rwn),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .ser_en     (ser_en),
    .ser_flag   (ser_flag),
    .ser_data   (ser_data),
    .irq        (irq)
  );

endmodule

// File: tb/hdlc_tx_seq_tb.sv
module hdlc_tx_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_ok = 1'b0;
  logic       len_wr = 1'b0;
  logic       clk_wr = 1'b0;
  logic       mem_req;
  logic       mem_rwn;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       mem_ack = 1'b0;
  logic       ser_en;
  logic       ser_flag;
  logic [7:0] ser_data;
  logic       ser_next = 1'b0;
  logic       irq;

  logic [7:0] mem [256];
  logic [8:0] exp_q [$];
  int         errors = 0;
  int         checks = 0;
  int         irq_cnt = 0;
  int         items = 0;
  int         ack_cnt = 0;
  int         next_wait = -1;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  hdlc_tx_seq dut_i (
    .clk (clk), .rst (rst), .clk_ok (clk_ok), .len_wr (len_wr), .clk_wr (clk_wr),
    .mem_req (mem_req), .mem_rwn (mem_rwn), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ack (mem_ack),
    .ser_en (ser_en), .ser_flag (ser_flag), .ser_data (ser_data),
    .ser_next (ser_next), .irq (irq)
  );

  assign mem_rdata = mem[mem_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // buffer model, serializer model and monitor, all at the falling edge
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      ack_cnt = 0;
    end else if (mem_req) begin
      ack_cnt++;
      if (ack_cnt == 2) begin
        mem_ack = 1'b1;
        if (!mem_rwn) mem[mem_addr] = mem_wdata;
      end
    end
    ser_next = 1'b0;
    if (next_wait > 0) begin
      next_wait--;
      if (next_wait == 0) begin
        ser_next = 1'b1;
        next_wait = -1;
      end
    end
    if (ser_en) begin
      items++;
      next_wait = 6;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R4/R8/R9 unexpected item", {ser_flag, ser_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({ser_flag, ser_data} == e, "R2/R3 item", {ser_flag, ser_data}, e);
      end
    end
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ mem[i][b];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic cpu_write(input int addr, input logic [7:0] val, input bit is_len);
    @(negedge clk);
    mem[addr] = val;
    if (is_len) len_wr = 1'b1;
    else        clk_wr = 1'b1;
    @(negedge clk);
    len_wr = 1'b0;
    clk_wr = 1'b0;
  endtask

  // driver: fill payload, push expected items, trigger
  task automatic send_frame(input int n, input int seed);
    logic [15:0] c;
    for (int i = 0; i < n; i++) mem[i] = 8'((i * 7 + seed) & 8'hFF);
    c = ref_crc(n);
    exp_q.push_back({1'b1, 8'h7E});
    for (int i = 0; i < n; i++) exp_q.push_back({1'b0, mem[i]});
    exp_q.push_back({1'b0, c[7:0]});
    exp_q.push_back({1'b0, c[15:8]});
    exp_q.push_back({1'b1, 8'h7E});
    cpu_write(255, 8'(n), 1'b1);
  endtask

  task automatic wait_irq(input int target);
    int guard;
    guard = 0;
    while (irq_cnt < target && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic frame_test(input int n, input int seed);
    int base;
    base = irq_cnt;
    send_frame(n, seed);
    wait_irq(base + 1);
    chk(exp_q.size() == 0, "R2 all items sent", exp_q.size(), 0);
    chk(mem[255] == 8'hFF, "R5 completion code", mem[255], 8'hFF);
    chk(irq_cnt == base + 1, "R5 one interrupt", irq_cnt, base + 1);
  endtask

  task automatic bad_len(input logic [7:0] v);
    int base;
    base = irq_cnt;
    cpu_write(255, v, 1'b1);
    repeat (40) @(negedge clk);
    chk(irq_cnt == base, "R4 no interrupt", irq_cnt, base);
    chk(mem[255] == v, "R4 location kept", mem[255], v);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[254] = 8'h33;
    repeat (4) @(negedge clk);
    chk(ser_en == 1'b0 && mem_req == 1'b0 && irq == 1'b0, "R1 during reset",
        {ser_en, mem_req, irq}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_en == 1'b0 && mem_req == 1'b0 && irq == 1'b0, "R1 after reset",
        {ser_en, mem_req, irq}, 0);
    next_wait = 3;
    // R8: start with no bit clock
    cpu_write(255, 8'd5, 1'b1);
    repeat (40) @(negedge clk);
    chk(irq_cnt == 0, "R8 no interrupt", irq_cnt, 0);
    chk(mem[255] == 8'd5, "R8 location kept", mem[255], 5);
    chk(mem[254] == 8'h33, "R6 no spurious status write", mem[254], 8'h33);
    // R6: clock appears
    clk_ok = 1'b1;
    repeat (20) @(negedge clk);
    chk(mem[254] == 8'hFF, "R6 status present", mem[254], 8'hFF);
    chk(irq_cnt == 1, "R6 change interrupt", irq_cnt, 1);
    // R7: quiet restore
    cpu_write(254, 8'h5A, 1'b0);
    repeat (20) @(negedge clk);
    chk(mem[254] == 8'hFF, "R7 status restored", mem[254], 8'hFF);
    chk(irq_cnt == 1, "R7 no interrupt", irq_cnt, 1);
    // R2 R3 R5 frames, including the boundary lengths
    frame_test(1, 3);
    frame_test(4, 17);
    frame_test(253, 91);
    // R4 invalid lengths
    bad_len(8'h00);
    bad_len(8'hFE);
    bad_len(8'hFF);
    // R9 start during a frame
    begin
      int base;
      base = irq_cnt;
      items = 0;
      send_frame(6, 40);
      while (items < 3) @(negedge clk);
      cpu_write(255, 8'd3, 1'b1);
      wait_irq(base + 1);
      repeat (80) @(negedge clk);
      chk(exp_q.size() == 0, "R9 running frame complete", exp_q.size(), 0);
      chk(irq_cnt == base + 1, "R9 single completion", irq_cnt, base + 1);
      chk(items == 10, "R9 item count", items, 10);
    end
    // R6 clock lost
    begin
      int base;
      base = irq_cnt;
      clk_ok = 1'b0;
      repeat (20) @(negedge clk);
      chk(mem[254] == 8'h00, "R6 status absent", mem[254], 0);
      chk(irq_cnt == base + 1, "R6 loss interrupt", irq_cnt, base + 1);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule